// File: doc/BRIEF.md
# BCD Calendar Clock with Coherent Access

This block keeps wall-clock time and the calendar date as packed BCD fields: seconds, minutes, hours, a weekday number, the day of the month, the month, a two-digit year, and one century bit. A reference pulse input is counted by a power-of-two prescaler, so one second equals exactly `2**REF_LOG2` reference pulses. Software reaches the block through a byte-wide register window of sixteen locations. Only the upper eight locations are populated.

Software never reads the running counters directly. It reads a visible copy that follows the counters one cycle behind. A control byte can freeze that copy so that a multi-byte read is coherent. It can also put the block in a hold state in which software edits the copy. Clearing the hold bit loads the whole edited time into the running counters in one cycle and restarts the prescaler at zero. Three configuration bits take effect on any write, held or not. One stops the time base. One replaces the seconds readback LSB with a 512 Hz square wave for frequency measurement. One lets the century bit flip when the year wraps.

The register bus is a plain control port. A write completes in the cycle `bus_sel` and `bus_we` are both high, and read data depends only on `bus_addr`, so there is no back-pressure to handle.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset, the time reads 00:00:00, the weekday byte reads 0x01, the date reads day 01, month 01, year 00, and the control byte reads 0x00. Stop, frequency test and century enable are all clear.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59 and wrap to 0x00, carrying into the next field. Hours count in BCD from 0x00 to 0x23 and wrap to 0x00, advancing the date.
- R3: The day of the month wraps to 0x01 after the last day of its month. That is day 31 for months 1, 3, 5, 7, 8, 10 and 12, and day 30 for months 4, 6, 9 and 11. For February it is day 29 when the year value is divisible by four and day 28 otherwise. Month 0x12 wraps to 0x01 and increments the year, and year 0x99 wraps to 0x00.
- R4: The weekday (1 to 7) increments on each date advance and wraps from 7 to 1.
- R5: On a wrap of the year from 0x99 to 0x00, the century bit inverts if century enable is set. If century enable is clear, the century bit is left unchanged.
- R6: The seconds field advances exactly once per `2**REF_LOG2` reference pulses. The prescaler restarts at zero when a hold is released.
- R7: While the hold bit (control bit 7) is set, writes to time fields land in the visible copy and read back at once. Clearing the hold bit loads the visible copy into the running counters. Writes to time fields made while the hold bit is clear have no effect.
- R8: While the freeze bit (control bit 6) is set, the visible copy stays constant and the running counters keep counting. After the bit clears, the copy shows the running time one cycle later.
- R9: Seconds register bit 7 is the stop bit and reads back as written. While it is set, neither the time nor the prescaler advances. It is written with or without hold.
- R10: Weekday register bit 6 enables frequency test. While it is set, seconds readback bit 0 equals prescaler bit `REF_LOG2-10`, which gives a 512 Hz square wave. Clearing it restores the stored bit 0.
- R11: The register map is: index 8 control {hold, freeze, 000000}; 9 {stop, seconds}; 10 minutes; 11 hours; 12 {0, freq test, century enable, century bit, 0, weekday[2:0]}; 13 day; 14 month; 15 year. Indices 0 to 7 read 0x00, and writes to them have no effect.
- R12: If a hold release and the end of a second fall in the same cycle, the loaded values win with no extra second added, and the next second takes a full `2**REF_LOG2` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference pulse counted by the prescaler |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 4 | Register index in the 16-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |

## Verification
Two collisions matter. The first is a hold release landing on the same clock edge as the final reference pulse of a second. The bench runs the prescaler to one pulse before the carry while the block is held. It then drives the release write and a reference pulse in the same cycle. It expects the loaded seconds with no increment, then checks that the next increment comes only after a further full count. The second collision is counting while frozen: time must keep running under a freeze, and the elapsed seconds must show up in the first read after the freeze clears.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SEC   = 4'd9;
  localparam logic [IDX_W-1:0] IDX_MIN   = 4'd10;
  localparam logic [IDX_W-1:0] IDX_HOUR  = 4'd11;
  localparam logic [IDX_W-1:0] IDX_WDAY  = 4'd12;
  localparam logic [IDX_W-1:0] IDX_DATE  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_MONTH = 4'd14;
  localparam logic [IDX_W-1:0] IDX_YEAR  = 4'd15;

  localparam int unsigned HOLD_BIT   = 7;
  localparam int unsigned FREEZE_BIT = 6;
  localparam int unsigned STOP_BIT   = 7;
  localparam int unsigned FTEST_BIT  = 6;
  localparam int unsigned CEN_BIT    = 5;
  localparam int unsigned CB_BIT     = 4;

  typedef struct packed {
    logic       cb;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{cb: 1'b0, year: 8'h00, month: 5'h01,
                                       date: 6'h01, wday: 3'd1, hour: 6'h00,
                                       min: 7'h00, sec: 7'h00};

  // Two-digit BCD increment (no wrap handling; callers compare first).
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // A BCD year is a multiple of four when its units digit, mod 4,
  // equals twice the parity of its tens digit.
  function automatic logic bcd_leap(input logic [7:0] yr);
    return yr[1:0] == {yr[4], 1'b0};
  endfunction

  function automatic logic [7:0] month_last_day(input logic [4:0] mon,
                                                input logic [7:0] yr);
    case (mon)
      5'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int unsigned REF_LOG2 = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic halt,
  input  logic restart,
  output logic sec_pulse,
  output logic ft_wave
);
  // Bit FT_BIT toggles every 2**FT_BIT pulses: 512 Hz when REF is 2**REF_LOG2 Hz.
  localparam int unsigned FT_BIT = (REF_LOG2 > 10) ? REF_LOG2 - 10 : 0;

  logic [REF_LOG2-1:0] div_q;
  logic                advance;

  assign advance   = ref_tick && !halt;
  assign sec_pulse = advance && (&div_q);
  assign ft_wave   = div_q[FT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (advance) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  input  logic      cent_en,
  output rtc_time_t cur
);
  rtc_time_t cur_q;
  rtc_time_t nxt;
  logic [7:0] last_day;

  assign last_day = month_last_day(cur_q.month, cur_q.year);
  assign cur      = cur_q;

  always_comb begin
    nxt = cur_q;
    if (cur_q.sec >= 7'h59) begin
      nxt.sec = '0;
      if (cur_q.min >= 7'h59) begin
        nxt.min = '0;
        if (cur_q.hour >= 6'h23) begin
          nxt.hour = '0;
          nxt.wday = (cur_q.wday >= 3'd7 || cur_q.wday == 3'd0) ? 3'd1 : cur_q.wday + 3'd1;
          if ({2'b00, cur_q.date} >= last_day) begin
            nxt.date = 6'h01;
            if (cur_q.month >= 5'h12) begin
              nxt.month = 5'h01;
              if (cur_q.year >= 8'h99) begin
                nxt.year = 8'h00;
                if (cent_en) nxt.cb = ~cur_q.cb;
              end else begin
                nxt.year = bcd_step(cur_q.year);
              end
            end else begin
              nxt.month = 5'(bcd_step({3'b000, cur_q.month}));
            end
          end else begin
            nxt.date = 6'(bcd_step({2'b00, cur_q.date}));
          end
        end else begin
          nxt.hour = 6'(bcd_step({2'b00, cur_q.hour}));
        end
      end else begin
        nxt.min = 7'(bcd_step({1'b0, cur_q.min}));
      end
    end else begin
      nxt.sec = 7'(bcd_step({1'b0, cur_q.sec}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur_q <= TIME_RESET;
    else if (load) cur_q <= load_val;
    else if (step) cur_q <= nxt;
  end
endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  rtc_time_t        live,
  input  logic             ft_wave,
  output rtc_time_t        vis,
  output logic             hold,
  output logic             freeze,
  output logic             stop,
  output logic             cent_en,
  output logic             load_req
);
  rtc_time_t vis_q;
  logic hold_q, freeze_q, stop_q, ft_q, cen_q;
  logic wr_any, wr_ctrl;

  assign wr_any   = bus_sel && bus_we;
  assign wr_ctrl  = wr_any && (bus_idx == IDX_CTRL);
  assign load_req = wr_ctrl && hold_q && !bus_wdata[HOLD_BIT];

  assign vis     = vis_q;
  assign hold    = hold_q;
  assign freeze  = freeze_q;
  assign stop    = stop_q;
  assign cent_en = cen_q;

  // Control and configuration bits: effective on any write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      freeze_q <= 1'b0;
      stop_q   <= 1'b0;
      ft_q     <= 1'b0;
      cen_q    <= 1'b0;
    end else if (wr_any) begin
      if (bus_idx == IDX_CTRL) begin
        hold_q   <= bus_wdata[HOLD_BIT];
        freeze_q <= bus_wdata[FREEZE_BIT];
      end
      if (bus_idx == IDX_SEC) stop_q <= bus_wdata[STOP_BIT];
      if (bus_idx == IDX_WDAY) begin
        ft_q  <= bus_wdata[FTEST_BIT];
        cen_q <= bus_wdata[CEN_BIT];
      end
    end
  end

  // Visible copy: edited under hold, frozen under freeze, else tracks live.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q <= TIME_RESET;
    end else if (hold_q) begin
      if (wr_any) begin
        case (bus_idx)
          IDX_SEC:   vis_q.sec   <= bus_wdata[6:0];
          IDX_MIN:   vis_q.min   <= bus_wdata[6:0];
          IDX_HOUR:  vis_q.hour  <= bus_wdata[5:0];
          IDX_WDAY: begin
            vis_q.cb   <= bus_wdata[CB_BIT];
            vis_q.wday <= bus_wdata[2:0];
          end
          IDX_DATE:  vis_q.date  <= bus_wdata[5:0];
          IDX_MONTH: vis_q.month <= bus_wdata[4:0];
          IDX_YEAR:  vis_q.year  <= bus_wdata;
          default: ;
        endcase
      end
    end else if (!freeze_q) begin
      vis_q <= live;
    end
  end

  always_comb begin
    case (bus_idx)
      IDX_CTRL:  bus_rdata = {hold_q, freeze_q, 6'b000000};
      IDX_SEC:   bus_rdata = {stop_q, vis_q.sec[6:1], ft_q ? ft_wave : vis_q.sec[0]};
      IDX_MIN:   bus_rdata = {1'b0, vis_q.min};
      IDX_HOUR:  bus_rdata = {2'b00, vis_q.hour};
      IDX_WDAY:  bus_rdata = {1'b0, ft_q, cen_q, vis_q.cb, 1'b0, vis_q.wday};
      IDX_DATE:  bus_rdata = {2'b00, vis_q.date};
      IDX_MONTH: bus_rdata = {3'b000, vis_q.month};
      IDX_YEAR:  bus_rdata = vis_q.year;
      default:   bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_top.sv
`timescale 1ns/1ps
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int unsigned REF_LOG2 = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  rtc_time_t live_q;
  rtc_time_t vis_q;
  logic hold_q, freeze_q, stop_q, cent_en, load_req;
  logic sec_pulse, ft_wave;

  rtc_prescaler #(.REF_LOG2(REF_LOG2)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .halt      (stop_q),
    .restart   (load_req),
    .sec_pulse (sec_pulse),
    .ft_wave   (ft_wave)
  );

  rtc_time_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sec_pulse),
    .load     (load_req),
    .load_val (vis_q),
    .cent_en  (cent_en),
    .cur      (live_q)
  );

  rtc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_idx   (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .live      (live_q),
    .ft_wave   (ft_wave),
    .vis       (vis_q),
    .hold      (hold_q),
    .freeze    (freeze_q),
    .stop      (stop_q),
    .cent_en   (cent_en),
    .load_req  (load_req)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input rtc_time_t live,
  input rtc_time_t vis,
  input logic      hold,
  input logic      freeze,
  input logic      stop,
  input logic      load_req
);
  p_hms_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live.sec[3:0] <= 4'd9 && live.sec <= 7'h59 &&
     live.min[3:0] <= 4'd9 && live.min <= 7'h59 &&
     live.hour[3:0] <= 4'd9 && live.hour <= 6'h23));

  p_date_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live.month >= 5'h01 && live.month <= 5'h12 &&
     live.date >= 6'h01 && live.date <= 6'h31));

  p_wday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live.wday >= 3'd1 && live.wday <= 3'd7));

  p_release_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (live == $past(vis)));

  p_freeze_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !hold) |=> $stable(vis));

  p_stop_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load_req) |=> $stable(live));
endmodule

bind rtc_calendar_top rtc_calendar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .live     (live_q),
  .vis      (vis_q),
  .hold     (hold_q),
  .freeze   (freeze_q),
  .stop     (stop_q),
  .load_req (load_req)
);

// File: tb/rtc_calendar_top_bench.sv
`timescale 1ns/1ps
module rtc_calendar_top_bench;
  localparam int unsigned LOG2 = 10;
  localparam int TPS = 1 << LOG2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_top #(.REF_LOG2(LOG2)) u_rtc_calendar_top (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit with_tick = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; ref_tick = with_tick;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // {sec, min, hour, wday byte, date, month, year}
  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    t = '0;
    for (int i = 9; i <= 15; i++) begin
      rd(4'(i), b);
      t = {t[47:0], b};
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr);
    wr(4'd8, 8'h80);
    wr(4'd9, s);  wr(4'd10, mi); wr(4'd11, h); wr(4'd12, wd);
    wr(4'd13, dt); wr(4'd14, mo); wr(4'd15, yr);
    wr(4'd8, 8'h00);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    int y, m, d, wd, nm, ny, nwd;
    int yrs[4];
    yrs = '{23, 24, 0, 99};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_time(t);
    chk("R1 reset time", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    rd(4'd8, b);
    chk("R1 reset control", {56'h0, b}, 64'h00);

    // R2 non-wrapping and carrying H:M:S steps
    set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS); read_time(t);
    chk("R2 sec 09->10", {8'h0, t}, {8'h0, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    set_time(8'h59, 8'h09, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS); read_time(t);
    chk("R2 min carry", {8'h0, t}, {8'h0, 8'h00, 8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    set_time(8'h59, 8'h59, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS); read_time(t);
    chk("R2 hour 09->10", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00});
    set_time(8'h59, 8'h59, 8'h19, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS); read_time(t);
    chk("R2 hour 19->20", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h20, 8'h01, 8'h01, 8'h01, 8'h00});

    // R3 R4 R2 end-of-month sweep over leap and non-leap years
    for (int yi = 0; yi < 4; yi++) begin
      for (int mm = 1; mm <= 12; mm++) begin
        y = yrs[yi]; m = mm; d = dim(m, y); wd = ((m + y) % 7) + 1;
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        nwd = (wd == 7) ? 1 : wd + 1;
        set_time(8'h59, 8'h59, 8'h23, 8'(wd), bcd(d), bcd(m), bcd(y));
        ticks(TPS); read_time(t);
        chk($sformatf("R3 R4 month end m=%0d y=%0d", m, y), {8'h0, t},
            {8'h0, 8'h00, 8'h00, 8'h00, 8'(nwd), 8'h01, bcd(nm), bcd(ny)});
      end
      // R3 February 28
      y = yrs[yi];
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, bcd(y));
      ticks(TPS); read_time(t);
      chk($sformatf("R3 feb28 y=%0d", y), {8'h0, t},
          {8'h0, 8'h00, 8'h00, 8'h00, 8'h01, (y % 4 == 0) ? 8'h29 : 8'h01,
           (y % 4 == 0) ? 8'h02 : 8'h03, bcd(y)});
    end

    // R5 century bit with enable set
    set_time(8'h59, 8'h59, 8'h23, 8'h23, 8'h31, 8'h12, 8'h99);
    ticks(TPS); read_time(t);
    chk("R5 century 0->1", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h00, 8'h34, 8'h01, 8'h01, 8'h00});
    set_time(8'h59, 8'h59, 8'h23, 8'h33, 8'h31, 8'h12, 8'h99);
    ticks(TPS); read_time(t);
    chk("R5 century 1->0", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h00, 8'h24, 8'h01, 8'h01, 8'h00});
    set_time(8'h59, 8'h59, 8'h23, 8'h13, 8'h31, 8'h12, 8'h99);
    ticks(TPS); read_time(t);
    chk("R5 century disabled", {8'h0, t}, {8'h0, 8'h00, 8'h00, 8'h00, 8'h14, 8'h01, 8'h01, 8'h00});

    // R6 exact second length
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS - 1); rd(4'd9, b);
    chk("R6 one pulse short", {56'h0, b}, 64'h30);
    ticks(1); @(negedge clk); rd(4'd9, b);
    chk("R6 full second", {56'h0, b}, 64'h31);

    // R7 hold: edits visible immediately, ignored without hold
    wr(4'd8, 8'h80); wr(4'd10, 8'h45); rd(4'd10, b);
    chk("R7 held write visible", {56'h0, b}, 64'h45);
    wr(4'd8, 8'h00); @(negedge clk); rd(4'd10, b);
    chk("R7 loaded on release", {56'h0, b}, 64'h45);
    wr(4'd10, 8'h12); @(negedge clk); rd(4'd10, b);
    chk("R7 unheld write ignored", {56'h0, b}, 64'h45);

    // R12 release collides with end of second
    set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd8, 8'h80); wr(4'd9, 8'h40);
    ticks(TPS - 1);
    wr(4'd8, 8'h00, 1'b1);
    @(negedge clk); rd(4'd9, b);
    chk("R12 load wins over tick", {56'h0, b}, 64'h40);
    ticks(TPS - 1); rd(4'd9, b);
    chk("R12 prescaler restarted", {56'h0, b}, 64'h40);
    ticks(1); @(negedge clk); rd(4'd9, b);
    chk("R12 next second", {56'h0, b}, 64'h41);

    // R8 freeze
    set_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd8, 8'h40);
    ticks(2 * TPS); rd(4'd9, b);
    chk("R8 frozen copy", {56'h0, b}, 64'h00);
    wr(4'd8, 8'h00); @(negedge clk); rd(4'd9, b);
    chk("R8 counters kept running", {56'h0, b}, 64'h02);

    // R9 stop bit
    wr(4'd9, 8'h80); rd(4'd9, b);
    chk("R9 stop reads back", {56'h0, b}, 64'h82);
    ticks(2 * TPS); rd(4'd9, b);
    chk("R9 no advance while stopped", {56'h0, b}, 64'h82);
    wr(4'd9, 8'h00); ticks(TPS); @(negedge clk); rd(4'd9, b);
    chk("R9 resumes", {56'h0, b}, 64'h03);

    // R10 frequency test
    set_time(8'h21, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd12, 8'h41); rd(4'd9, b);
    chk("R10 ft phase 0", {56'h0, b}, 64'h20);
    ticks(1); rd(4'd9, b);
    chk("R10 ft phase 1", {56'h0, b}, 64'h21);
    ticks(1); rd(4'd9, b);
    chk("R10 ft phase 2", {56'h0, b}, 64'h20);
    wr(4'd12, 8'h01); rd(4'd9, b);
    chk("R10 ft off", {56'h0, b}, 64'h21);

    // R11 map: control readback, empty lower window
    wr(4'd8, 8'hC0); rd(4'd8, b);
    chk("R11 control readback", {56'h0, b}, 64'hC0);
    for (int i = 0; i < 8; i++) wr(4'(i), 8'hFF);
    wr(4'd8, 8'h00); @(negedge clk);
    read_time(t);
    chk("R11 low window writes no effect", {8'h0, t},
        {8'h0, 8'h21, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] r;
      rd(4'(i), r);
      b = b | r;
    end
    chk("R11 low window reads zero", {56'h0, b}, 64'h00);

    done = 1'b1;
    finish_up();
  end
endmodule